// File: doc/BRIEF.md
# Prescaled Reference-Match Timer

A 16-bit up-counting timer with a small byte-addressed register port. Software picks a clock source (the system clock, or the system clock slowed by a further factor of sixteen), an 8-bit prescale value and a reference value. It then sets the run bit. The counter advances once every (prescale + 1) source ticks. Each time it reaches the reference value, a sticky reference event is recorded. If the interrupt enable is set, that event drives the interrupt line high until software clears it.

Two counting styles are available. In restart style the count returns to zero after it matches the reference, which makes a periodic tick. In free style the count keeps climbing through the reference value and wraps past its top. Clearing the run bit is destructive: the mode and reference settings are wiped, so the timer has to be set up again before it runs.

Top module: `refcmp_timer`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: The counter keeps its value unless mode bit 0 (run) is 1 and mode bits 2:1 (source) hold code 1 or code 2. Codes 0 and 3 leave it halted. A write to the counter still loads it while it is halted.
- R3: A mode write that takes bit 0 from 1 to 0 clears both the mode register and the reference register. Any other mode write stores the written value and leaves the reference untouched.
- R4: With source code 1, the counter increments once every (P + 1) clock cycles, where P is mode bits 15:8. The phase is counted from the most recent mode or reference write.
- R5: With source code 2, the counter increments once every 16 × (P + 1) clock cycles, with the phase counted in the same way.
- R6: When mode bit 3 is 1, the increment that would follow a count equal to the reference value yields 0 instead. When bit 3 is 0, the counter steps by one and wraps from 0xFFFF to 0.
- R7: When the counter takes on the reference value through counting, event bit 1 (reference flag) becomes 1. Event bit 0 (capture flag) is never set by this block.
- R8: The event flags are sticky. A write to the event register clears each flag whose data bit is 1 and leaves the others as they are.
- R9: `irq` is high exactly when mode bit 4 (interrupt enable) and the reference flag are both 1.
- R10: The registers sit at byte offsets mode 0x00, reference 0x04, capture 0x08, counter 0x0C and events 0x11. Reads are combinational, and any other offset reads zero. The capture register is plain read/write storage. A counter write loads the counter, and a counter read returns the live count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Write strobe, sampled on the rising clock edge |
| addr | input | 5 | Byte offset of the register accessed |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data for `addr` (combinational) |
| irq | output | 1 | Reference-match interrupt request |

## Verification
A prescaler whose phase is off shows up as a counter value that is too high or too low at the first read after a mode write. In divide-by-sixteen mode the error appears within 16 × (P + 1) cycles. A wrong restart or wrap decision shows up as a count that exceeds the reference, or one that fails to come back to zero, within one reference period. A reference flag that is lost or cleared by mistake shows up as a wrong event read or a wrong `irq` level right after the match, or right after the clearing write.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
    parameter int unsigned TMR_W  = 16;
    parameter int unsigned ADDR_W = 5;
    parameter int unsigned PSC_W  = 8;
    parameter int unsigned DIV_W  = 4;
    localparam int unsigned PSC_LSB = 8;

    localparam logic [ADDR_W-1:0] OFS_MODE = 5'h00;
    localparam logic [ADDR_W-1:0] OFS_REF  = 5'h04;
    localparam logic [ADDR_W-1:0] OFS_CAPT = 5'h08;
    localparam logic [ADDR_W-1:0] OFS_CNT  = 5'h0C;
    localparam logic [ADDR_W-1:0] OFS_EVT  = 5'h11;

    localparam int unsigned B_RUN  = 0;
    localparam int unsigned B_WRAP = 3;
    localparam int unsigned B_IEN  = 4;
    localparam int unsigned E_REF  = 1;

    localparam logic [1:0] SRC_SYS  = 2'd1;
    localparam logic [1:0] SRC_SLOW = 2'd2;

    typedef struct packed {
        logic [TMR_W-1:0] mode;
        logic [TMR_W-1:0] refv;
        logic [TMR_W-1:0] capt;
        logic [1:0]       evt;
    } regs_t;
endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int unsigned PSC_W = 8,
    parameter int unsigned DIV_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             restart,
    input  logic             slow_sel,
    input  logic [PSC_W-1:0] psc_cur,
    input  logic [PSC_W-1:0] psc_load,
    output logic             tick
);
    typedef struct packed {
        logic [DIV_W-1:0] dcnt;
        logic [PSC_W-1:0] pcnt;
    } pst_t;

    pst_t st_q, st_d;
    logic stage;

    always_comb begin
        st_d  = st_q;
        stage = slow_sel ? (st_q.dcnt == '1) : 1'b1;
        tick  = run && !restart && stage && (st_q.pcnt == '0);
        if (restart || !run) begin
            st_d.dcnt = '0;
            st_d.pcnt = restart ? psc_load : psc_cur;
        end else begin
            st_d.dcnt = st_q.dcnt + DIV_W'(1);
            if (stage) begin
                st_d.pcnt = (st_q.pcnt == '0) ? psc_cur : st_q.pcnt - PSC_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    AST_TICK_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && psc_cur != '0) |=> !tick); // R4
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
    parameter int unsigned W = 16
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         tick,
    input  logic         wrap_en,
    input  logic [W-1:0] ref_val,
    input  logic         load,
    input  logic [W-1:0] load_val,
    output logic [W-1:0] cnt,
    output logic         hit
);
    logic [W-1:0] cnt_q, cnt_d, step;

    always_comb begin
        step  = (wrap_en && cnt_q == ref_val) ? '0 : cnt_q + W'(1);
        hit   = tick && !load && (step == ref_val);
        cnt_d = cnt_q;
        if (load)      cnt_d = load_val;
        else if (tick) cnt_d = step;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign cnt = cnt_q;

    AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && wrap_en && cnt_q == ref_val) |=> (cnt_q == '0)); // R6
    AST_FREE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && !load && !wrap_en) |=> (cnt_q == $past(cnt_q) + W'(1))); // R6
endmodule

// File: rtl/refcmp_timer.sv
module refcmp_timer
    import tmr_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [TMR_W-1:0]  wdata,
    output logic [TMR_W-1:0]  rdata,
    output logic              irq
);
    regs_t regs_q, regs_d;
    logic wr_mode, wr_ref, wr_capt, wr_cnt, wr_evt;
    logic restart, run, slow, tick, hit;
    logic [1:0] src;
    logic [PSC_W-1:0] psc_load;
    logic [TMR_W-1:0] cnt;

    always_comb begin
        wr_mode = wr_en && (addr == OFS_MODE);
        wr_ref  = wr_en && (addr == OFS_REF);
        wr_capt = wr_en && (addr == OFS_CAPT);
        wr_cnt  = wr_en && (addr == OFS_CNT);
        wr_evt  = wr_en && (addr == OFS_EVT);

        regs_d = regs_q;
        if (wr_mode) begin
            if (regs_q.mode[B_RUN] && !wdata[B_RUN]) begin
                regs_d.mode = '0;
                regs_d.refv = '0;
            end else begin
                regs_d.mode = wdata;
            end
        end
        if (wr_ref)  regs_d.refv = wdata;
        if (wr_capt) regs_d.capt = wdata;
        if (wr_evt)  regs_d.evt  = regs_q.evt & ~wdata[1:0];
        if (hit)     regs_d.evt[E_REF] = 1'b1;

        restart  = wr_mode || wr_ref;
        psc_load = wr_mode ? regs_d.mode[PSC_LSB +: PSC_W] : regs_q.mode[PSC_LSB +: PSC_W];
        src      = regs_q.mode[2:1];
        run      = regs_q.mode[B_RUN] && (src == SRC_SYS || src == SRC_SLOW);
        slow     = (src == SRC_SLOW);

        case (addr)
            OFS_MODE: rdata = regs_q.mode;
            OFS_REF:  rdata = regs_q.refv;
            OFS_CAPT: rdata = regs_q.capt;
            OFS_CNT:  rdata = cnt;
            OFS_EVT:  rdata = TMR_W'(regs_q.evt);
            default:  rdata = '0;
        endcase
        irq = regs_q.mode[B_IEN] && regs_q.evt[E_REF];
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    tmr_prescaler #(.PSC_W(PSC_W), .DIV_W(DIV_W)) u_psc (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .restart  (restart),
        .slow_sel (slow),
        .psc_cur  (regs_q.mode[PSC_LSB +: PSC_W]),
        .psc_load (psc_load),
        .tick     (tick)
    );

    tmr_counter #(.W(TMR_W)) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .tick     (tick),
        .wrap_en  (regs_q.mode[B_WRAP]),
        .ref_val  (regs_q.refv),
        .load     (wr_cnt),
        .load_val (wdata),
        .cnt      (cnt),
        .hit      (hit)
    );

    AST_HALT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!regs_q.mode[B_RUN] && !wr_cnt) |=> $stable(cnt)); // R2
    AST_STOP_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_mode && regs_q.mode[B_RUN] && !wdata[B_RUN]) |=> (regs_q.mode == '0 && regs_q.refv == '0)); // R3
    AST_HIT_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        hit |=> regs_q.evt[E_REF]); // R7
    AST_REF_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (regs_q.evt[E_REF] && !(wr_evt && wdata[E_REF])) |=> regs_q.evt[E_REF]); // R8
endmodule

// File: tb/tb_refcmp_timer.sv
`timescale 1ns/1ps
module tb_refcmp_timer;
    localparam int PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [4:0]  addr = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;
    logic        irq;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    refcmp_timer dut (.clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr),
                      .wdata(wdata), .rdata(rdata), .irq(irq));

    always #(PERIOD/2) clk = ~clk;

    localparam logic [4:0] A_MODE = 5'h00, A_REF = 5'h04, A_CAPT = 5'h08,
                           A_CNT = 5'h0C, A_EVT = 5'h11;

    function automatic int exp_free(int m, int p, bit slow);
        int per = slow ? 16 * (p + 1) : (p + 1);
        return (m / per) % 65536;
    endfunction

    function automatic int exp_wrap(int m, int p, int r);
        return (m / (p + 1)) % (r + 1);
    endfunction

    task automatic check(string req, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(logic [4:0] a, logic [15:0] d);
        @(negedge clk);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk);
        #1 wr_en = 1'b0;
    endtask

    // caller must be in the low clock phase
    task automatic peek(logic [4:0] a, output logic [15:0] v);
        addr = a;
        #1 v = rdata;
    endtask

    task automatic rd(logic [4:0] a, output logic [15:0] v);
        @(negedge clk);
        peek(a, v);
    endtask

    task automatic wait_edges(int m);
        repeat (m) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(PERIOD * 150000);
        n_chk++; n_fail++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] v, e;
        int p, m, r;
        void'($urandom(32'd4711));
        #(PERIOD * 3);
        rst_n = 1'b1;

        // R1: reset state
        foreach (e[i]) begin end
        rd(A_MODE, v); check("R1 mode", v, 0);
        peek(A_REF, v);  check("R1 ref", v, 0);
        peek(A_CAPT, v); check("R1 capt", v, 0);
        peek(A_CNT, v);  check("R1 cnt", v, 0);
        peek(A_EVT, v);  check("R1 evt", v, 0);
        check("R1 irq", irq, 0);

        // R10: map, storage, unmapped reads, counter load
        for (int i = 0; i < 4; i++) begin
            logic [15:0] a0, a1;
            a0 = 16'($urandom); a1 = 16'($urandom);
            wr(A_REF, a0); wr(A_CAPT, a1);
            rd(A_REF, v);  check("R10 ref rw", v, a0);
            peek(A_CAPT, v); check("R10 capt rw", v, a1);
        end
        rd(5'h10, v); check("R10 unmapped 0x10", v, 0);
        peek(5'h14, v); check("R10 unmapped 0x14", v, 0);
        peek(5'h02, v); check("R10 unmapped 0x02", v, 0);
        wr(A_CNT, 16'h3A5C);
        rd(A_CNT, v); check("R10 cnt load", v, 16'h3A5C);
        wait_edges(20);
        rd(A_CNT, v); check("R2 halted run=0", v, 16'h3A5C);

        // R2: run set but source codes 0 and 3 halt
        wr(A_MODE, 16'h0001); wait_edges(30);
        rd(A_CNT, v); check("R2 src0 halt", v, 16'h3A5C);
        wr(A_MODE, 16'h0007); wait_edges(30);
        rd(A_CNT, v); check("R2 src3 halt", v, 16'h3A5C);
        wr(A_CNT, 16'h0042);
        rd(A_CNT, v); check("R2 load while halted", v, 16'h0042);
        wr(A_MODE, 16'h0000);

        // R4: system clock source, random prescale, free style
        for (int i = 0; i < 8; i++) begin
            p = $urandom_range(0, 7); m = $urandom_range(0, 120);
            wr(A_MODE, 16'h0000); wr(A_REF, 16'hFFFF); wr(A_CNT, 16'h0000);
            wr(A_MODE, 16'((p << 8) | 16'h0003));
            wait_edges(m);
            rd(A_CNT, v); check("R4 sys rate", v, exp_free(m, p, 0));
        end

        // R5: slow source
        for (int i = 0; i < 5; i++) begin
            p = $urandom_range(0, 3); m = $urandom_range(0, 300);
            wr(A_MODE, 16'h0000); wr(A_REF, 16'hFFFF); wr(A_CNT, 16'h0000);
            wr(A_MODE, 16'((p << 8) | 16'h0005));
            wait_edges(m);
            rd(A_CNT, v); check("R5 slow rate", v, exp_free(m, p, 1));
        end

        // R6/R7: restart style with event
        for (int i = 0; i < 6; i++) begin
            p = $urandom_range(0, 2); r = $urandom_range(3, 10); m = $urandom_range(0, 60);
            wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'(r)); wr(A_CNT, 16'h0000);
            wr(A_MODE, 16'((p << 8) | 16'h000B));
            wait_edges(m);
            rd(A_CNT, v); check("R6 restart count", v, exp_wrap(m, p, r));
            peek(A_EVT, v); check("R7 ref flag", v, (m / (p + 1) >= r) ? 2 : 0);
        end

        // R6: free style wraps past top; R7 flag on reaching ref 0
        wr(A_MODE, 16'h0000); wr(A_EVT, 16'h0003); wr(A_REF, 16'h0000);
        wr(A_CNT, 16'hFFFD); wr(A_MODE, 16'h0003);
        wait_edges(5);
        rd(A_CNT, v); check("R6 free wrap", v, 16'h0002);
        peek(A_EVT, v); check("R7 flag at wrap", v, 2);
        check("R9 irq disabled", irq, 0);

        // R9/R8: enable irq with halted source, then clear flags
        wr(A_MODE, 16'h0011);
        rd(A_EVT, v); check("R8 flag survives mode write", v, 2);
        check("R9 irq high", irq, 1);
        wr(A_EVT, 16'h0001);
        rd(A_EVT, v); check("R8 write 0 keeps flag", v, 2);
        check("R9 irq still high", irq, 1);
        wr(A_EVT, 16'h0002);
        rd(A_EVT, v); check("R8 write 1 clears", v, 0);
        check("R9 irq low after clear", irq, 0);

        // R3: stop clears mode and ref
        wr(A_REF, 16'h0055); wr(A_MODE, 16'h0003);
        wr(A_MODE, 16'h0A00);
        rd(A_MODE, v); check("R3 stop clears mode", v, 0);
        peek(A_REF, v); check("R3 stop clears ref", v, 0);
        wr(A_REF, 16'h1234); wr(A_MODE, 16'h0A0C);
        rd(A_MODE, v); check("R3 plain mode write", v, 16'h0A0C);
        peek(A_REF, v); check("R3 ref kept", v, 16'h1234);

        // R10: counter load while running continues from loaded value
        wr(A_MODE, 16'h0000); wr(A_REF, 16'hFFFF); wr(A_MODE, 16'h0003);
        wait_edges(7);
        wr(A_CNT, 16'h0100);
        wait_edges(4);
        rd(A_CNT, v); check("R10 load while running", v, 16'h0104);

        finish_run();
    end
endmodule